// File: doc/BRIEF.md
# Calendar Real-Time Clock Counter

This block keeps wall-clock time and a calendar date inside a synchronous design. A programmable prescaler divides the reference clock into one-second ticks. Each tick advances a cascade of counters: seconds, minutes, hours, then day of week and day of month, month and year. The day counter follows the real length of each month, and February takes its leap-year length from the current year.

Software sets the clock by placing a date word and a time word on the setup inputs and pulsing a load strobe while the clock is stopped. The load also restarts the prescaler. It then raises the enable input. A registered running flag reports when the clock has taken up the enable, and the current date and time are always visible as packed read-only words. A separate override input turns off leap-year handling, so that February always has 28 days.

Top module: `cal_clock_top`

## Requirements
- R1: While running, the prescaler with value `divM1` produces one tick every `divM1`+1 reference clocks. When enable is raised on a stopped, freshly loaded clock, the first tick lands `divM1`+2 clock edges after the first edge that samples enable high.
- R2: `active` equals the value of `enable` sampled at the previous clock edge. While `active` is low, the date and time outputs hold their value unless a load takes place.
- R3: When `loadStb` is seen with `active` low, the outputs show the setup words at the next edge and the prescaler restarts from zero. Date packing: year in [23:12], month in [11:8] (1 to 12), day in [4:0] (1 to 31). Time packing: day of week in [26:24] (1 = Monday through 7 = Sunday), hour in [20:16], minute in [13:8], second in [5:0]. A load seen while `active` is high changes nothing.
- R4: Seconds wrap from 59 to 0 and carry into minutes. Minutes wrap from 59 to 0 and carry into hours. Hours wrap from 23 to 0 and carry into the day counters. A carry that stops early leaves the higher fields untouched.
- R5: On every day rollover, the day of week advances by one and wraps from 7 to 1.
- R6: The day of month wraps to 1 after 30 days in April, June, September and November, after 31 days in the other non-February months, and after 28 or 29 days in February. The month wraps from 12 to 1 and then increments the year.
- R7: With `noLeap` low, a year that is divisible by 4 is a leap year, except a year divisible by 100 and not by 400. February of a leap year has 29 days.
- R8: With `noLeap` high, February always has 28 days.
- R9: After reset, both output words are zero, `active` is low and the prescaler is at zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rstN | input | 1 | Active-low synchronous reset |
| divM1 | input | 16 | Prescaler value: the tick period minus one |
| enable | input | 1 | Run request |
| loadStb | input | 1 | Copy the setup words into the counters (only while stopped) |
| noLeap | input | 1 | Force February to 28 days |
| setDate | input | 24 | Setup date word |
| setTime | input | 27 | Setup time word |
| active | output | 1 | Clock is running |
| curDate | output | 24 | Current date word |
| curTime | output | 27 | Current time word |

## Verification
The bench builds the block with its default widths: a 16-bit prescaler and a 12-bit year. It drives `divM1` at 3 and at 9, so each one-second tick costs only a few clock cycles. Because the setup words can place the clock one second before any boundary, every carry chain can be reached in a single tick. This covers year end, the end of a 30-day month, and the February cases for leap years, common years, centuries and the 400-year exception, with and without the override.

// File: rtl/cal_clock_pkg.sv
package cal_clock_pkg;

  // strobes sent from the control to the datapath
  typedef struct packed {
    logic tick;
    logic load;
  } calStrobe_t;

  // packed field positions (decoded by software, kept fixed)
  localparam int DAY_LO   = 0;
  localparam int DAY_W    = 5;
  localparam int MONTH_LO = 8;
  localparam int MONTH_W  = 4;
  localparam int YEAR_LO  = 12;
  localparam int SEC_LO   = 0;
  localparam int SEC_W    = 6;
  localparam int MIN_LO   = 8;
  localparam int MIN_W    = 6;
  localparam int HOUR_LO  = 16;
  localparam int HOUR_W   = 5;
  localparam int DOTW_LO  = 24;
  localparam int DOTW_W   = 3;
  localparam int TIME_W   = DOTW_LO + DOTW_W;

  function automatic logic isLeapYear(input logic [11:0] yr, input logic forceOff);
    logic by4;
    logic by100;
    logic by400;
    by4   = (yr[1:0] == 2'b00);
    by100 = ((yr % 12'd100) == 12'd0);
    by400 = ((yr % 12'd400) == 12'd0);
    return !forceOff && by4 && (!by100 || by400);
  endfunction

  function automatic logic [4:0] daysInMonth(input logic [3:0] mon, input logic leap);
    case (mon)
      4'd2:                      return leap ? 5'd29 : 5'd28;
      4'd4, 4'd6, 4'd9, 4'd11:   return 5'd30;
      default:                   return 5'd31;
    endcase
  endfunction

endpackage

// File: rtl/cal_clock_ctrl.sv
module cal_clock_ctrl
  import cal_clock_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divM1,
  input  logic             enable,
  input  logic             loadStb,
  output logic             active,
  output calStrobe_t       stb
);

  logic [DIV_W-1:0] preCnt;
  logic             activeQ;
  logic             wrapNow;
  logic             loadOk;

  assign wrapNow = activeQ && (preCnt >= divM1);
  assign loadOk  = loadStb && !activeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
    end else begin
      activeQ <= enable;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (loadOk) begin
      preCnt <= '0;
    end else if (activeQ) begin
      if (wrapNow) preCnt <= '0;
      else         preCnt <= preCnt + 1'b1;
    end
  end

  always_comb begin
    stb.tick = wrapNow;
    stb.load = loadOk;
  end

  assign active = activeQ;

endmodule

// File: rtl/cal_clock_datapath.sv
module cal_clock_datapath
  import cal_clock_pkg::*;
#(
  parameter int YEAR_W = 12,
  localparam int DATE_W = YEAR_LO + YEAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        stb,
  input  logic              noLeap,
  input  logic [DATE_W-1:0] setDate,
  input  logic [TIME_W-1:0] setTime,
  output logic [DATE_W-1:0] curDate,
  output logic [TIME_W-1:0] curTime
);

  logic [SEC_W-1:0]   secQ,   secN;
  logic [MIN_W-1:0]   minQ,   minN;
  logic [HOUR_W-1:0]  hourQ,  hourN;
  logic [DOTW_W-1:0]  dotwQ,  dotwN;
  logic [DAY_W-1:0]   dayQ,   dayN;
  logic [MONTH_W-1:0] monQ,   monN;
  logic [YEAR_W-1:0]  yearQ,  yearN;
  logic               leapNow;
  logic [4:0]         monLen;
  logic [11:0]        yearLow;

  assign yearLow = 12'(yearQ);
  assign leapNow = isLeapYear(yearLow, noLeap);
  assign monLen  = daysInMonth(monQ, leapNow);

  always_comb begin
    secN  = secQ;
    minN  = minQ;
    hourN = hourQ;
    dotwN = dotwQ;
    dayN  = dayQ;
    monN  = monQ;
    yearN = yearQ;
    if (stb.load) begin
      secN  = setTime[SEC_LO  +: SEC_W];
      minN  = setTime[MIN_LO  +: MIN_W];
      hourN = setTime[HOUR_LO +: HOUR_W];
      dotwN = setTime[DOTW_LO +: DOTW_W];
      dayN  = setDate[DAY_LO   +: DAY_W];
      monN  = setDate[MONTH_LO +: MONTH_W];
      yearN = setDate[YEAR_LO  +: YEAR_W];
    end else if (stb.tick) begin
      if (secQ >= SEC_W'(59)) begin
        secN = '0;
        if (minQ >= MIN_W'(59)) begin
          minN = '0;
          if (hourQ >= HOUR_W'(23)) begin
            hourN = '0;
            dotwN = (dotwQ >= DOTW_W'(7)) ? DOTW_W'(1) : dotwQ + 1'b1;
            if (dayQ >= monLen) begin
              dayN = DAY_W'(1);
              if (monQ >= MONTH_W'(12)) begin
                monN  = MONTH_W'(1);
                yearN = yearQ + 1'b1;
              end else begin
                monN = monQ + 1'b1;
              end
            end else begin
              dayN = dayQ + 1'b1;
            end
          end else begin
            hourN = hourQ + 1'b1;
          end
        end else begin
          minN = minQ + 1'b1;
        end
      end else begin
        secN = secQ + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      secQ  <= '0;
      minQ  <= '0;
      hourQ <= '0;
      dotwQ <= '0;
      dayQ  <= '0;
      monQ  <= '0;
      yearQ <= '0;
    end else begin
      secQ  <= secN;
      minQ  <= minN;
      hourQ <= hourN;
      dotwQ <= dotwN;
      dayQ  <= dayN;
      monQ  <= monN;
      yearQ <= yearN;
    end
  end

  always_comb begin
    curDate = '0;
    curDate[DAY_LO   +: DAY_W]   = dayQ;
    curDate[MONTH_LO +: MONTH_W] = monQ;
    curDate[YEAR_LO  +: YEAR_W]  = yearQ;
    curTime = '0;
    curTime[SEC_LO  +: SEC_W]  = secQ;
    curTime[MIN_LO  +: MIN_W]  = minQ;
    curTime[HOUR_LO +: HOUR_W] = hourQ;
    curTime[DOTW_LO +: DOTW_W] = dotwQ;
  end

endmodule

// File: rtl/cal_clock_top.sv
module cal_clock_top
  import cal_clock_pkg::*;
#(
  parameter int DIV_W  = 16,
  parameter int YEAR_W = 12,
  localparam int DATE_W = YEAR_LO + YEAR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DIV_W-1:0]  divM1,
  input  logic              enable,
  input  logic              loadStb,
  input  logic              noLeap,
  input  logic [DATE_W-1:0] setDate,
  input  logic [TIME_W-1:0] setTime,
  output logic              active,
  output logic [DATE_W-1:0] curDate,
  output logic [TIME_W-1:0] curTime
);

  calStrobe_t stb;

  cal_clock_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .divM1   (divM1),
    .enable  (enable),
    .loadStb (loadStb),
    .active  (active),
    .stb     (stb)
  );

  cal_clock_datapath #(.YEAR_W(YEAR_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .noLeap  (noLeap),
    .setDate (setDate),
    .setTime (setTime),
    .curDate (curDate),
    .curTime (curTime)
  );

endmodule

// File: rtl/cal_clock_chk.sv
module cal_clock_chk
  import cal_clock_pkg::*;
#(
  parameter int DATE_W = 24
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              loadStb,
  input logic              active,
  input logic              tick,
  input logic [DATE_W-1:0] setDate,
  input logic [TIME_W-1:0] setTime,
  input logic [DATE_W-1:0] curDate,
  input logic [TIME_W-1:0] curTime
);

  AST_ACTIVE_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> active == $past(enable)); // R2

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!active && !loadStb) |=> ($stable(curDate) && $stable(curTime))); // R2

  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (!rstN)
    (!active && loadStb) |=> (curDate == $past(setDate) && curTime == $past(setTime))); // R3

  AST_LOAD_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (active && loadStb && !tick) |=> ($stable(curDate) && $stable(curTime))); // R3

  AST_TICK_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> active); // R1

  AST_SEC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (tick && curTime[SEC_LO +: SEC_W] < 6'd59) |=>
      (curTime[SEC_LO +: SEC_W] == $past(curTime[SEC_LO +: SEC_W]) + 6'd1)); // R4

endmodule

bind cal_clock_top cal_clock_chk #(.DATE_W(DATE_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .enable  (enable),
  .loadStb (loadStb),
  .active  (active),
  .tick    (stb.tick),
  .setDate (setDate),
  .setTime (setTime),
  .curDate (curDate),
  .curTime (curTime)
);

// File: tb/sim_cal_clock_top.sv
module sim_cal_clock_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] divM1 = 16'd3;
  logic        enable = 1'b0;
  logic        loadStb = 1'b0;
  logic        noLeap = 1'b0;
  logic [23:0] setDate = '0;
  logic [26:0] setTime = '0;
  logic        active;
  logic [23:0] curDate;
  logic [26:0] curTime;

  int nChecks = 0;
  int nFails  = 0;

  typedef struct {
    logic [23:0] dateV;
    logic [26:0] timeV;
    string       tag;
  } expItem_t;

  expItem_t scoreQ[$];
  event     sampleEv;
  bit       monDone = 1'b0;

  always #10 clk = ~clk;

  cal_clock_top u0 (
    .clk(clk), .rstN(rstN), .divM1(divM1), .enable(enable), .loadStb(loadStb),
    .noLeap(noLeap), .setDate(setDate), .setTime(setTime),
    .active(active), .curDate(curDate), .curTime(curTime)
  );

  function automatic logic [23:0] mkDate(int y, int m, int d);
    return {12'(y), 4'(m), 3'b0, 5'(d)};
  endfunction

  function automatic logic [26:0] mkTime(int w, int h, int mi, int s);
    return {3'(w), 3'b0, 5'(h), 2'b0, 6'(mi), 2'b0, 6'(s)};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item and compares at the sample point
  initial begin
    forever begin
      @(sampleEv);
      if (scoreQ.size() == 0) begin
        check("monitor empty queue", 64'd1, 64'd0);
      end else begin
        expItem_t it;
        it = scoreQ.pop_front();
        check({it.tag, " date"}, 64'(curDate), 64'(it.dateV));
        check({it.tag, " time"}, 64'(curTime), 64'(it.timeV));
      end
    end
  end

  task automatic stopClock();
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic loadSetup(input logic [23:0] d, input logic [26:0] t, input logic nl);
    setDate = d;
    setTime = t;
    noLeap  = nl;
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    check("R3 load date", 64'(curDate), 64'(d));
    check("R3 load time", 64'(curTime), 64'(t));
  endtask

  // counts edges until the time word changes
  task automatic waitChange(output int edges);
    logic [26:0] pre;
    pre = curTime;
    edges = 0;
    while (curTime == pre && edges < 200) begin
      @(negedge clk);
      edges++;
    end
  endtask

  // driver: load a moment one second before a boundary, run one tick
  task automatic runCase(input string tag,
                         input logic [23:0] d0, input logic [26:0] t0, input logic nl,
                         input logic [23:0] d1, input logic [26:0] t1);
    int edges;
    stopClock();
    loadSetup(d0, t0, nl);
    enable = 1'b1;
    waitChange(edges);
    check({tag, " R1 first tick latency"}, 64'(edges), 64'(divM1) + 64'd2);
    scoreQ.push_back('{dateV: d1, timeV: t1, tag: tag});
    ->sampleEv;
    #1;
  endtask

  initial begin
    int edges;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R9 reset date", 64'(curDate), 64'd0);
    check("R9 reset time", 64'(curTime), 64'd0);
    check("R9 reset active", 64'(active), 64'd0);
    @(negedge clk);
    check("R2 idle hold", 64'(curTime), 64'd0);

    // year end, all carries
    runCase("R4 R5 R6 year end",
      mkDate(2023, 12, 31), mkTime(7, 23, 59, 59), 1'b0,
      mkDate(2024, 1, 1),   mkTime(1, 0, 0, 0));
    check("R2 active high", 64'(active), 64'd1);

    // tick period and load ignored while running
    setDate = mkDate(1999, 5, 5);
    setTime = mkTime(3, 3, 3, 3);
    loadStb = 1'b1;
    @(negedge clk);
    loadStb = 1'b0;
    check("R3 load ignored date", 64'(curDate), 64'(mkDate(2024, 1, 1)));
    check("R3 load ignored time", 64'(curTime), 64'(mkTime(1, 0, 0, 0)));
    waitChange(edges);
    check("R1 period", 64'(edges) + 64'd1, 64'(divM1) + 64'd1);
    scoreQ.push_back('{dateV: mkDate(2024, 1, 1), timeV: mkTime(1, 0, 0, 1), tag: "R4 second step"});
    ->sampleEv;
    #1;

    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check("R2 active low", 64'(active), 64'd0);

    runCase("R4 minute carry",
      mkDate(2023, 6, 15), mkTime(4, 10, 15, 59), 1'b0,
      mkDate(2023, 6, 15), mkTime(4, 10, 16, 0));
    runCase("R4 hour carry",
      mkDate(2023, 6, 15), mkTime(4, 10, 59, 59), 1'b0,
      mkDate(2023, 6, 15), mkTime(4, 11, 0, 0));
    runCase("R6 thirty day month",
      mkDate(2023, 4, 30), mkTime(5, 23, 59, 59), 1'b0,
      mkDate(2023, 5, 1),  mkTime(6, 0, 0, 0));
    runCase("R6 R7 leap feb 28",
      mkDate(2024, 2, 28), mkTime(3, 23, 59, 59), 1'b0,
      mkDate(2024, 2, 29), mkTime(4, 0, 0, 0));
    runCase("R7 leap feb 29",
      mkDate(2024, 2, 29), mkTime(4, 23, 59, 59), 1'b0,
      mkDate(2024, 3, 1),  mkTime(5, 0, 0, 0));
    runCase("R6 common feb",
      mkDate(2023, 2, 28), mkTime(2, 23, 59, 59), 1'b0,
      mkDate(2023, 3, 1),  mkTime(3, 0, 0, 0));
    runCase("R7 century not leap",
      mkDate(2100, 2, 28), mkTime(7, 23, 59, 59), 1'b0,
      mkDate(2100, 3, 1),  mkTime(1, 0, 0, 0));
    runCase("R7 year 2000 leap",
      mkDate(2000, 2, 28), mkTime(1, 23, 59, 59), 1'b0,
      mkDate(2000, 2, 29), mkTime(2, 0, 0, 0));
    runCase("R8 override",
      mkDate(2024, 2, 28), mkTime(3, 23, 59, 59), 1'b1,
      mkDate(2024, 3, 1),  mkTime(4, 0, 0, 0));
    divM1 = 16'd9;
    runCase("R1 R5 other divider",
      mkDate(2023, 7, 31), mkTime(7, 23, 59, 59), 1'b0,
      mkDate(2023, 8, 1),  mkTime(1, 0, 0, 0));

    stopClock();
    monDone = 1'b1;
  end

  initial begin
    fork
      begin
        wait (monDone);
      end
      begin
        repeat (100000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    #5;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule